// File: doc/BRIEF.md
# UART Flow-Control and Line-Error Interrupt Pending Logic

This block holds the pending flags for four receive-side UART interrupt sources. The sources are line errors (parity, framing or break on a received character), reception of an Xoff character, reception of an Xon character, and reception of a programmed special character. The receiver datapath sends single-cycle event pulses and per-character error flags. The interrupt-status reader sends a read strobe. The block returns one registered pending bit for each source. A priority encoder elsewhere turns these bits into an interrupt identity.

Two configuration bits change the behaviour:

- **Error-timing bit.** It selects when a bad character raises the line-error interrupt. It can fire when the character is pushed into the receive FIFO. It can instead fire later, when the character reaches the receive holding register at the head of the FIFO.
- **Clear-mode bit.** It selects whether later received traffic can also withdraw the Xoff and special-character interrupts. With the bit clear, an Xon character withdraws the Xoff interrupt and the next character withdraws the special-character interrupt. With the bit set, only a status read clears either one. The Xon interrupt is always cleared by a status read alone.

Top module: `uart_fc_int_pend`

## Requirements
- R1: While reset is asserted, all four pending outputs are 0.
- R2: With `cfg_err_early` = 0, `line_err_pend` is set only by `rhr_load` with a nonzero `rhr_err`. The error bits are bit0 parity, bit1 framing and bit2 break. A FIFO push carrying errors has no effect on it.
- R3: With `cfg_err_early` = 1, `line_err_pend` is set by `rx_push` with a nonzero `rx_push_err`, using the same bit meanings as R2. A holding-register load carrying errors has no effect on it.
- R4: `xon_pend` is set by `xon_det`. It is cleared only by `isr_rd`: received characters and Xoff events leave it set.
- R5: With `cfg_read_clear_only` = 0, `xoff_pend` is cleared by `isr_rd` or by `xon_det`.
- R6: With `cfg_read_clear_only` = 0, `spec_pend` is cleared by `isr_rd` or by a later `rx_push`.
- R7: With `cfg_read_clear_only` = 1, `xoff_pend` and `spec_pend` are cleared only by `isr_rd`. Xon events and received characters leave them set.
- R8: When a set event and a clear condition for the same source arrive in the same cycle, the pending bit ends up set.
- R9: Every pending output is a register. It rises on the clock edge that samples the set event and falls on the edge that samples the clear condition. Without either, it holds its value.
- R10: `line_err_pend` is cleared by `isr_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_err_early | input | 1 | 1: line error flagged at FIFO entry; 0: at holding-register arrival |
| cfg_read_clear_only | input | 1 | 1: Xoff/special interrupts cleared only by status read |
| rx_push | input | 1 | A received character is written into the RX FIFO |
| rx_push_err | input | ERR_W | Error flags of the pushed character (bit0 parity, bit1 framing, bit2 break) |
| rhr_load | input | 1 | A character becomes the receive holding register entry |
| rhr_err | input | ERR_W | Error flags of that character |
| xoff_det | input | 1 | Xoff character received |
| xon_det | input | 1 | Xon character received |
| spec_det | input | 1 | Special character received |
| isr_rd | input | 1 | Interrupt-status read strobe |
| line_err_pend | output | 1 | Line-error interrupt pending |
| xoff_pend | output | 1 | Xoff interrupt pending |
| xon_pend | output | 1 | Xon interrupt pending |
| spec_pend | output | 1 | Special-character interrupt pending |

## Verification
All state lives in four flags, and each flag drives its own output directly. A flag that is wrongly held, dropped or set therefore shows at the ports on the very next cycle. The bench runs a behavioural model beside the design and compares all four bits on every cycle, so a fault appears in the cycle after the triggering stimulus. The directed sequences cover the following, and a seeded random phase then mixes events, modes and reads:

- the wrong-timing error sources,
- the mode-dependent clears,
- set and clear arriving together.

// File: rtl/uic_pkg.sv
package uic_pkg;

  localparam int NUM_SRC = 4;

  typedef enum logic [1:0] {
    SRC_LINE = 2'd0,
    SRC_XOFF = 2'd1,
    SRC_XON  = 2'd2,
    SRC_SPEC = 2'd3
  } src_e;

  // Line-error trigger: the active observation point depends on the timing mode.
  function automatic logic line_err_event(input logic early,
                                          input logic push, input logic push_bad,
                                          input logic load, input logic load_bad);
    return early ? (push & push_bad) : (load & load_bad);
  endfunction

  // Clear for a mode-dependent source: a status read always clears it;
  // the alternate traffic-based clear is allowed only when not read-only.
  function automatic logic mode_clear(input logic read_only,
                                      input logic rd, input logic alt);
    return rd | (~read_only & alt);
  endfunction

endpackage

// File: rtl/uic_event_sel.sv
module uic_event_sel
  import uic_pkg::*;
#(
  parameter int ERR_W = 3
) (
  input  logic               cfg_err_early,
  input  logic               cfg_read_clear_only,
  input  logic               rx_push,
  input  logic [ERR_W-1:0]   rx_push_err,
  input  logic               rhr_load,
  input  logic [ERR_W-1:0]   rhr_err,
  input  logic               xoff_det,
  input  logic               xon_det,
  input  logic               spec_det,
  input  logic               isr_rd,
  output logic [NUM_SRC-1:0] set_vec,
  output logic [NUM_SRC-1:0] clr_vec
);

  logic push_bad;
  logic load_bad;

  assign push_bad = |rx_push_err;
  assign load_bad = |rhr_err;

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    set_vec[int'(SRC_LINE)] = line_err_event(cfg_err_early, rx_push, push_bad,
                                             rhr_load, load_bad);
    set_vec[int'(SRC_XOFF)] = xoff_det;
    set_vec[int'(SRC_XON)]  = xon_det;
    set_vec[int'(SRC_SPEC)] = spec_det;
    clr_vec[int'(SRC_LINE)] = isr_rd;
    clr_vec[int'(SRC_XON)]  = isr_rd;
    clr_vec[int'(SRC_XOFF)] = mode_clear(cfg_read_clear_only, isr_rd, xon_det);
    clr_vec[int'(SRC_SPEC)] = mode_clear(cfg_read_clear_only, isr_rd, rx_push);
  end

endmodule

// File: rtl/uic_pend_bit.sv
module uic_pend_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end

  // R8: a set in the same cycle as a clear leaves the bit set
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);

  // R9: a clear without a set drops the bit on the sampling edge
  p_clear_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);

  // R9: with neither a set nor a clear, the bit keeps its value
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o));

endmodule

// File: rtl/uart_fc_int_pend.sv
module uart_fc_int_pend
  import uic_pkg::*;
#(
  parameter int ERR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_err_early,
  input  logic             cfg_read_clear_only,
  input  logic             rx_push,
  input  logic [ERR_W-1:0] rx_push_err,
  input  logic             rhr_load,
  input  logic [ERR_W-1:0] rhr_err,
  input  logic             xoff_det,
  input  logic             xon_det,
  input  logic             spec_det,
  input  logic             isr_rd,
  output logic             line_err_pend,
  output logic             xoff_pend,
  output logic             xon_pend,
  output logic             spec_pend
);

  logic [NUM_SRC-1:0] set_vec;
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_SRC-1:0] pend;

  // Named events, visible to the assertions below
  logic push_err_seen;
  logic rhr_err_seen;
  assign push_err_seen = rx_push && (rx_push_err != '0);
  assign rhr_err_seen  = rhr_load && (rhr_err != '0);

  uic_event_sel #(.ERR_W(ERR_W)) u_sel (
    .cfg_err_early       (cfg_err_early),
    .cfg_read_clear_only (cfg_read_clear_only),
    .rx_push             (rx_push),
    .rx_push_err         (rx_push_err),
    .rhr_load            (rhr_load),
    .rhr_err             (rhr_err),
    .xoff_det            (xoff_det),
    .xon_det             (xon_det),
    .spec_det            (spec_det),
    .isr_rd              (isr_rd),
    .set_vec             (set_vec),
    .clr_vec             (clr_vec)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_pend
    uic_pend_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec[g]),
      .clr_i (clr_vec[g]),
      .q_o   (pend[g])
    );
  end

  assign line_err_pend = pend[int'(SRC_LINE)];
  assign xoff_pend     = pend[int'(SRC_XOFF)];
  assign xon_pend      = pend[int'(SRC_XON)];
  assign spec_pend     = pend[int'(SRC_SPEC)];

  // R2: in late mode, only a holding-register arrival with errors can raise the line flag
  p_late_only_rhr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_err_early && !line_err_pend && !rhr_err_seen) |=> !line_err_pend);

  // R3: in early mode, only a FIFO push with errors can raise the line flag
  p_early_only_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err_early && !line_err_pend && !push_err_seen) |=> !line_err_pend);

  // R4: Xon pending survives everything except a status read
  p_xon_read_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xon_pend && !isr_rd) |=> xon_pend);

  // R5: an Xon character withdraws Xoff in clear mode 0
  p_xoff_by_xon_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_read_clear_only && xon_det && !xoff_det) |=> !xoff_pend);

  // R6: the next character withdraws the special-character flag in clear mode 0
  p_spec_by_char_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_read_clear_only && rx_push && !spec_det) |=> !spec_pend);

  // R7: in clear mode 1, only a status read removes Xoff or special
  p_xoff_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_read_clear_only && xoff_pend && !isr_rd) |=> xoff_pend);
  p_spec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_read_clear_only && spec_pend && !isr_rd) |=> spec_pend);

  // R10: a status read with no new line error clears the line flag
  p_line_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && !push_err_seen && !rhr_err_seen) |=> !line_err_pend);

endmodule

// File: tb/sim_uart_fc_int_pend.sv
`timescale 1ns/1ps
module sim_uart_fc_int_pend;

  localparam int EW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_err_early = 1'b0;
  logic cfg_read_clear_only = 1'b0;
  logic rx_push = 1'b0;
  logic [EW-1:0] rx_push_err = '0;
  logic rhr_load = 1'b0;
  logic [EW-1:0] rhr_err = '0;
  logic xoff_det = 1'b0;
  logic xon_det = 1'b0;
  logic spec_det = 1'b0;
  logic isr_rd = 1'b0;
  logic line_err_pend, xoff_pend, xon_pend, spec_pend;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // Behavioural reference state
  int m_line = 0, m_xoff = 0, m_xon = 0, m_spec = 0;

  always #2 clk = ~clk;

  uart_fc_int_pend #(.ERR_W(EW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_err_early(cfg_err_early), .cfg_read_clear_only(cfg_read_clear_only),
    .rx_push(rx_push), .rx_push_err(rx_push_err),
    .rhr_load(rhr_load), .rhr_err(rhr_err),
    .xoff_det(xoff_det), .xon_det(xon_det), .spec_det(spec_det),
    .isr_rd(isr_rd),
    .line_err_pend(line_err_pend), .xoff_pend(xoff_pend),
    .xon_pend(xon_pend), .spec_pend(spec_pend)
  );

  // Reference model: updated at each edge from the inputs held since the last falling edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_line = 0; m_xoff = 0; m_xon = 0; m_spec = 0;
    end else begin
      int err_now;
      if (cfg_err_early) err_now = (rx_push && rx_push_err != 0) ? 1 : 0;
      else               err_now = (rhr_load && rhr_err != 0) ? 1 : 0;
      if (err_now != 0) m_line = 1;
      else if (isr_rd) m_line = 0;
      if (xon_det) m_xon = 1;
      else if (isr_rd) m_xon = 0;
      if (xoff_det) m_xoff = 1;
      else if (isr_rd) m_xoff = 0;
      else if (!cfg_read_clear_only && xon_det) m_xoff = 0;
      if (spec_det) m_spec = 1;
      else if (isr_rd) m_spec = 0;
      else if (!cfg_read_clear_only && rx_push) m_spec = 0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cmp_model(input string req);
    int act, exp;
    act = {line_err_pend, xoff_pend, xon_pend, spec_pend};
    exp = (m_line << 3) | (m_xoff << 2) | (m_xon << 1) | m_spec;
    chk(req, "model {line,xoff,xon,spec}", act, exp);
  endtask

  task automatic idle_inputs();
    rx_push = 0; rx_push_err = '0; rhr_load = 0; rhr_err = '0;
    xoff_det = 0; xon_det = 0; spec_det = 0; isr_rd = 0;
  endtask

  // Inputs are set at a falling edge; one rising edge samples them; compare at the next falling edge
  task automatic cyc(input string req);
    @(posedge clk);
    @(negedge clk);
    cmp_model(req);
    idle_inputs();
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1", "line in reset", int'(line_err_pend), 0);
    chk("R1", "xoff in reset", int'(xoff_pend), 0);
    chk("R1", "xon in reset",  int'(xon_pend), 0);
    chk("R1", "spec in reset", int'(spec_pend), 0);
    rst_n = 1;
    cyc("R9");

    // R2: late timing
    cfg_err_early = 0; cfg_read_clear_only = 0;
    rx_push = 1; rx_push_err = 3'b001; cyc("R2");
    chk("R2", "push error ignored", int'(line_err_pend), 0);
    rhr_load = 1; rhr_err = 3'b000; cyc("R2");
    chk("R2", "clean rhr", int'(line_err_pend), 0);
    rhr_load = 1; rhr_err = 3'b010; cyc("R2");
    chk("R2", "framing at rhr", int'(line_err_pend), 1);
    isr_rd = 1; cyc("R10");
    chk("R10", "read clears line", int'(line_err_pend), 0);

    // R3: early timing
    cfg_err_early = 1;
    rhr_load = 1; rhr_err = 3'b100; cyc("R3");
    chk("R3", "rhr error ignored", int'(line_err_pend), 0);
    rx_push = 1; rx_push_err = 3'b100; cyc("R3");
    chk("R3", "break at push", int'(line_err_pend), 1);
    isr_rd = 1; cyc("R10");
    chk("R10", "read clears line early", int'(line_err_pend), 0);

    // R4: Xon
    xon_det = 1; cyc("R4");
    chk("R4", "xon set", int'(xon_pend), 1);
    rx_push = 1; cyc("R4");
    xoff_det = 1; cyc("R4");
    chk("R4", "xon kept", int'(xon_pend), 1);
    isr_rd = 1; cyc("R4");
    chk("R4", "xon read", int'(xon_pend), 0);

    // R5: Xoff clear mode 0
    xoff_det = 1; cyc("R5");
    xon_det = 1; cyc("R5");
    chk("R5", "xoff cleared by xon", int'(xoff_pend), 0);
    isr_rd = 1; cyc("R5");
    xoff_det = 1; cyc("R5");
    isr_rd = 1; cyc("R5");
    chk("R5", "xoff cleared by read", int'(xoff_pend), 0);

    // R6: special clear mode 0
    spec_det = 1; rx_push = 1; cyc("R6");
    chk("R6", "spec set with its own char", int'(spec_pend), 1);
    rx_push = 1; cyc("R6");
    chk("R6", "spec cleared by next char", int'(spec_pend), 0);
    spec_det = 1; cyc("R6");
    isr_rd = 1; cyc("R6");
    chk("R6", "spec cleared by read", int'(spec_pend), 0);

    // R7: clear mode 1
    cfg_read_clear_only = 1;
    xoff_det = 1; spec_det = 1; cyc("R7");
    xon_det = 1; cyc("R7");
    chk("R7", "xoff held over xon", int'(xoff_pend), 1);
    rx_push = 1; cyc("R7");
    chk("R7", "spec held over char", int'(spec_pend), 1);
    isr_rd = 1; cyc("R7");
    chk("R7", "xoff read", int'(xoff_pend), 0);
    chk("R7", "spec read", int'(spec_pend), 0);

    // R8: set beats clear
    xoff_det = 1; spec_det = 1; isr_rd = 1; cyc("R8");
    chk("R8", "xoff set over read", int'(xoff_pend), 1);
    chk("R8", "spec set over read", int'(spec_pend), 1);
    isr_rd = 1; cyc("R8");
    cfg_read_clear_only = 0;
    xoff_det = 1; xon_det = 1; cyc("R8");
    chk("R8", "xoff set over xon", int'(xoff_pend), 1);
    cfg_err_early = 0;
    rhr_load = 1; rhr_err = 3'b001; isr_rd = 1; cyc("R8");
    chk("R8", "line set over read", int'(line_err_pend), 1);
    isr_rd = 1; cyc("R8");

    // Random mix, compared every cycle
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 64) == 0) cfg_err_early = $urandom % 2;
      if (($urandom % 64) == 0) cfg_read_clear_only = $urandom % 2;
      rx_push = ($urandom % 3) == 0;
      rx_push_err = (($urandom % 4) == 0) ? EW'($urandom) : '0;
      rhr_load = ($urandom % 3) == 0;
      rhr_err = (($urandom % 4) == 0) ? EW'($urandom) : '0;
      xoff_det = ($urandom % 8) == 0;
      xon_det = ($urandom % 8) == 0;
      spec_det = ($urandom % 8) == 0;
      isr_rd = ($urandom % 6) == 0;
      cyc("R9");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule